// File: doc/BRIEF.md
# Trigger-Committed Fractional Clock Divider

This block turns a free-running input clock into a train of single-cycle clock-enable pulses. The average pulse rate is the input rate divided by a programmable divisor that has an integer part and a fractional part. Software writes the divisor into a field of a 32-bit configuration word. That write only stages the value. The divider does not use it until software writes a one to a separate trigger input.

The divisor field stores one less than the intended divisor. The low `FRAC_WIDTH` bits of the field hold the fraction, and the implied plus-one applies only to the integer bits above them. The divisor therefore equals `(field >> FRAC_WIDTH) + 1 + (field mod 2^FRAC_WIDTH) / 2^FRAC_WIDTH`.

Each output period lasts the integer divisor in input cycles. A phase accumulator adds the fraction once per period, and each accumulator overflow lengthens that period by one input cycle. A committed change takes effect at a period boundary. While the change waits, the busy flag reads one. The change is only carried out while the gate input is open.

Top module: `fdiv_top`

## Requirements
- R1: After reset the busy flag is 0 and the active field is 0 (divisor 1), so `tick` is high in every cycle while `gate_open` is 1.
- R2: With the fraction bits zero, a field value `v` gives ticks exactly `(v >> FRAC_WIDTH) + 1` input cycles apart.
- R3: With fraction `f` (low `FRAC_WIDTH` bits), the accumulator restarts at 0 when a divisor is adopted. Each period adds `f`, and a period is one cycle longer whenever the running sum reaches `2^FRAC_WIDTH`. For example, field 17 with `FRAC_WIDTH`=2 gives periods 5,5,5,6.
- R4: The divisor field is `reg_wdata[FIELD_SHIFT +: FIELD_WIDTH]` (bits 11:4 by default). All other bits of the written word have no effect on the tick pattern.
- R5: A register write without a trigger leaves the tick pattern unchanged.
- R6: A cycle with `trig_wr` high makes `trig_busy` read 1 from the next cycle. The flag stays 1 until the staged field is adopted.
- R7: Adoption happens only on a cycle where `tick` is high while busy is already set. The period in progress finishes at its old length, the new length starts right after that tick, and busy reads 0 in the following cycle.
- R8: While `gate_open` is 0, `tick` stays 0, the period count is frozen, and a pending trigger stays pending.
- R9: The all-ones field (255 by default) gives the largest divisor, 64.75, which produces periods 64,65,65,65.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_open | input | 1 | Clock gate enable; divider runs only while high |
| reg_wr | input | 1 | Write strobe for the staged configuration word |
| reg_wdata | input | 32 | Configuration word carrying the divisor field |
| trig_wr | input | 1 | Writes one to the commit trigger |
| trig_busy | output | 1 | Trigger readback: 1 while a commit is pending |
| tick | output | 1 | Clock-enable pulse, one cycle per output period |

## Verification
A wrong period count shows up at the next tick, which arrives early or late. A corrupted accumulator only distorts the carry pattern, so it can take up to `2^FRAC_WIDTH` periods to show as a misplaced long period. A busy flag that sets or clears at the wrong time is visible on `trig_busy` in the very next cycle. An early adoption shortens or stretches the period that contains the trigger. The bench compares both outputs against a behavioural model on every cycle, so each of these faults is caught at its first visible cycle.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
   localparam int unsigned FDIV_WORD_W = 32;
   typedef logic [FDIV_WORD_W-1:0] fdiv_word_t;

   function automatic int unsigned fdiv_eff_width(input int unsigned w);
      return (w == 0) ? 1 : w;
   endfunction
endpackage

// File: rtl/fdiv_cfg.sv
module fdiv_cfg
   import fdiv_pkg::*;
#(
   parameter int unsigned FIELD_SHIFT = 4,
   parameter int unsigned FIELD_WIDTH = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  fdiv_word_t             reg_wdata,
   input  logic                   trig_wr,
   input  logic                   boundary,
   output logic                   busy,
   output logic                   adopt,
   output logic [FIELD_WIDTH-1:0] field_use
);
   logic [FIELD_WIDTH-1:0] staged_q;
   logic [FIELD_WIDTH-1:0] active_q;

   assign adopt     = busy & boundary;
   assign field_use = adopt ? staged_q : active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= '0;
         active_q <= '0;
         busy     <= 1'b0;
      end else begin
         if (reg_wr) staged_q <= reg_wdata[FIELD_SHIFT +: FIELD_WIDTH];
         if (adopt) active_q <= staged_q;
         if (trig_wr) busy <= 1'b1;
         else if (adopt) busy <= 1'b0;
      end
   end

   assert_trig_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> busy);
   assert_pending_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !boundary) |=> busy);
   assert_clear_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(boundary));
endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
   parameter int unsigned FRAC_WIDTH = 2,
   localparam int unsigned FE = (FRAC_WIDTH == 0) ? 1 : FRAC_WIDTH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          restart,
   input  logic [FE-1:0] frac,
   output logic          carry
);
   generate
      if (FRAC_WIDTH == 0) begin : g_integer
         assign carry = 1'b0;
      end else begin : g_fraction
         logic [FE-1:0] acc_q;
         logic [FE:0]   sum;

         assign sum   = {1'b0, (restart ? {FE{1'b0}} : acc_q)} + {1'b0, frac};
         assign carry = sum[FE];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) acc_q <= '0;
            else if (step) acc_q <= sum[FE-1:0];
         end

         assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !step |=> $stable(acc_q));
         assert_acc_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (step && restart) |=> (acc_q == $past(frac)));
      end
   endgenerate
endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt #(
   parameter int unsigned CNT_WIDTH = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic [CNT_WIDTH-1:0] load_val,
   output logic                 at_zero
);
   logic [CNT_WIDTH-1:0] cnt_q;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (run) begin
         if (at_zero) cnt_q <= load_val;
         else cnt_q <= cnt_q - 1'b1;
      end
   end

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_q));
   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
   import fdiv_pkg::*;
#(
   parameter int unsigned FIELD_SHIFT = 4,
   parameter int unsigned FIELD_WIDTH = 8,
   parameter int unsigned FRAC_WIDTH  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        gate_open,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   input  logic        trig_wr,
   output logic        trig_busy,
   output logic        tick
);
   localparam int unsigned INT_W = FIELD_WIDTH - FRAC_WIDTH;
   localparam int unsigned CNT_W = INT_W + 1;
   localparam int unsigned FE    = fdiv_eff_width(FRAC_WIDTH);

   generate
      if (FIELD_SHIFT + FIELD_WIDTH > FDIV_WORD_W) begin : g_bad_span
         $error("divisor field does not fit in the configuration word");
      end
      if (FRAC_WIDTH >= FIELD_WIDTH) begin : g_bad_frac
         $error("fraction must leave at least one integer bit");
      end
   endgenerate

   logic                   at_zero;
   logic                   boundary;
   logic                   adopt;
   logic                   carry;
   logic [FIELD_WIDTH-1:0] field_use;
   logic [INT_W-1:0]       int_part;
   logic [FE-1:0]          frac_part;
   logic [CNT_W-1:0]       load_val;

   assign boundary = gate_open & at_zero;
   assign tick     = boundary;
   assign int_part = field_use[FIELD_WIDTH-1:FRAC_WIDTH];

   generate
      if (FRAC_WIDTH == 0) begin : g_no_frac
         assign frac_part = '0;
      end else begin : g_frac
         assign frac_part = field_use[FE-1:0];
      end
   endgenerate

   assign load_val = {1'b0, int_part} + {{INT_W{1'b0}}, carry};

   fdiv_cfg #(
      .FIELD_SHIFT(FIELD_SHIFT),
      .FIELD_WIDTH(FIELD_WIDTH)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .trig_wr   (trig_wr),
      .boundary  (boundary),
      .busy      (trig_busy),
      .adopt     (adopt),
      .field_use (field_use)
   );

   fdiv_phase_acc #(
      .FRAC_WIDTH(FRAC_WIDTH)
   ) i_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (boundary),
      .restart (adopt),
      .frac    (frac_part),
      .carry   (carry)
   );

   fdiv_period_cnt #(
      .CNT_WIDTH(CNT_W)
   ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (gate_open),
      .load_val (load_val),
      .at_zero  (at_zero)
   );

   assert_no_tick_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_open |-> !tick);
   assert_busy_drop_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_busy && !tick) |=> trig_busy);
endmodule

// File: tb/test_fdiv_top.sv
module test_fdiv_top;
   localparam int SH = 4;
   localparam int FW = 8;
   localparam int FRW = 2;
   localparam int FMASK = (1 << FW) - 1;
   localparam int FDIV = 1 << FRW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gate_open = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        trig_wr = 1'b0;
   logic        trig_busy;
   logic        tick;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_rem, m_acc, m_busy, m_active, m_staged;

   always #5 clk = ~clk;

   fdiv_top #(.FIELD_SHIFT(SH), .FIELD_WIDTH(FW), .FRAC_WIDTH(FRW)) i_fdiv_top (
      .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .trig_wr(trig_wr), .trig_busy(trig_busy), .tick(tick)
   );

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_rem = 0; m_acc = 0; m_busy = 0; m_active = 0; m_staged = 0;
      end else begin
         bit et, ad;
         int f, s;
         et = gate_open && (m_rem == 0);
         ad = et && (m_busy != 0);
         if (et) begin
            f = ad ? m_staged : m_active;
            s = (ad ? 0 : m_acc) + (f % FDIV);
            m_acc = s % FDIV;
            m_rem = (f / FDIV) + ((s >= FDIV) ? 1 : 0);
            if (ad) m_active = f;
         end else if (gate_open) begin
            m_rem = m_rem - 1;
         end
         if (trig_wr) m_busy = 1;
         else if (ad) m_busy = 0;
         if (reg_wr) m_staged = int'((reg_wdata >> SH) & FMASK);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit et;
         et = gate_open && (m_rem == 0);
         n_chk++;
         if (tick !== et || trig_busy !== m_busy[0]) begin
            n_fail++;
            $display("FAIL R2 R3 R6 model: tick=%0b busy=%0b expected tick=%0b busy=%0b",
                     tick, trig_busy, et, m_busy[0]);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input bit wr, input logic [31:0] d, input bit tg);
      @(posedge clk); #1;
      reg_wr = wr; reg_wdata = d; trig_wr = tg;
      @(posedge clk); #1;
      reg_wr = 1'b0; trig_wr = 1'b0;
   endtask

   task automatic wait_adopt();
      do @(negedge clk); while (!(tick && trig_busy));
   endtask

   task automatic meas(input int start, output int n);
      n = start;
      do begin @(negedge clk); n++; end while (!tick);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int n, cnt;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1; gate_open = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", trig_busy, 0);
      cnt = 0;
      for (int i = 0; i < 5; i++) begin @(negedge clk); cnt += tick; end
      chk("R1 ticks per cycle at divisor 1", cnt, 5);

      // R5: staged write without trigger
      drive(1'b1, 32'(8 << SH), 1'b0);
      cnt = 0;
      for (int i = 0; i < 6; i++) begin @(negedge clk); cnt += tick; end
      chk("R5 write without trigger", cnt, 6);

      // R6 / R2: commit divisor 3
      drive(1'b0, 32'(8 << SH), 1'b1);
      chk("R6 busy after trigger", trig_busy, 1);
      wait_adopt();
      for (int i = 0; i < 3; i++) begin
         meas(0, n); chk("R2 integer period", n, 3);
      end
      @(negedge clk);
      chk("R7 busy cleared after adoption", trig_busy, 0);

      // R3 / R4: divisor 5.25 with noise outside the field
      drive(1'b1, 32'hFFFF_F00F | 32'(17 << SH), 1'b1);
      wait_adopt();
      meas(0, n); chk("R3 R4 period 1", n, 5);
      meas(0, n); chk("R3 R4 period 2", n, 5);
      meas(0, n); chk("R3 R4 period 3", n, 5);
      meas(0, n); chk("R3 R4 period 4", n, 6);

      // R8: gate closed keeps trigger pending and ticks quiet
      @(posedge clk); #1;
      gate_open = 1'b0; reg_wr = 1'b1; reg_wdata = 32'(8 << SH); trig_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; trig_wr = 1'b0;
      cnt = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += tick; end
      chk("R8 ticks while gated", cnt, 0);
      chk("R8 busy while gated", trig_busy, 1);
      @(posedge clk); #1 gate_open = 1'b1;
      wait_adopt();
      meas(0, n); chk("R8 period after reopening", n, 3);

      // R7: trigger mid-period, old period finishes first
      reg_wr = 1'b1; reg_wdata = 32'(4 << SH); trig_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0; trig_wr = 1'b0;
      meas(0, n); chk("R7 old period completes", n, 3);
      meas(0, n); chk("R7 new period", n, 2);

      // R9: all-ones field
      drive(1'b1, 32'(FMASK << SH), 1'b1);
      wait_adopt();
      meas(0, n); chk("R9 max period 1", n, 64);
      meas(0, n); chk("R9 max period 2", n, 65);
      meas(0, n); chk("R9 max period 3", n, 65);
      meas(0, n); chk("R9 max period 4", n, 65);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule